// File: doc/BRIEF.md
# Register-Programmed SPI Master

This peripheral drives a four-wire serial bus as a master. It is controlled through a small register window: a control byte, a status byte, an 8-bit clock divider, a 16-bit frame command word and a 32-bit data register. Each write to the data register sends exactly one frame. The command word sets the frame length, the bit order, the clock polarity and phase, which of the two slave selects is used, and whether that select stays low between frames.

In full-duplex operation the word shifted in from MISO is placed in the data register at the end of the frame. The receive-full flag then sets, and software collects the word by reading the data register. To receive only, software writes a dummy word to start the clock. A transmit-only mode drops the received word. If a frame completes while an earlier word is still unread, the overrun flag sets. A single level-sensitive interrupt line combines the two data flags with their enables.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset the status register reads 0x20 (only transmit-empty set), both slave selects are high, SCK is low and the interrupt is low.
- R2: Each SCK half period lasts divider+1 module clocks, the divider being the byte at offset 2. SCK idles at the CPOL level (command bit 1) and returns to it after every frame.
- R3: Command bits [11:8] set the frame length. A code c from 7 to 15 gives c+1 bits, codes 0, 1 and 2 give 20, 24 and 32 bits, and codes 3 to 6 give 8 bits. A frame has exactly twice that many SCK edges.
- R4: With command bit 12 set, bits go out and come in least significant first. Otherwise they go most significant first. The received word is right-aligned in the data register, with the bits above the frame length reading zero.
- R5: With CPHA (command bit 0) clear, MISO is sampled on the leading SCK edges and MOSI changes on the trailing edges. With CPHA set, MOSI changes on the leading edges and MISO is sampled on the trailing edges.
- R6: Transmit-empty (status bit 5) clears on a data write. It sets again in the clock after that, when the word moves into the shift register of an idle engine.
- R7: When transmit-only mode is off, receive-full (status bit 7) sets at the end of each frame and clears when the data register (offset 4) is read.
- R8: With transmit-only mode on (control bit 1), a frame leaves receive-full clear and the data register unchanged.
- R9: Overrun (status bit 0) sets when a frame ends while receive-full is still set. The new word is then discarded. Writing status bit 0 as 0 clears overrun, and writing it as 1 leaves it unchanged.
- R10: The interrupt is high exactly while (receive-full and control bit 7) or (transmit-empty and control bit 5).
- R11: A frame starts only while both control bit 6 (enable) and control bit 3 (master) are set. Command bit 4 picks ss_n[0] or ss_n[1]. The chosen select is low during a frame. With command bit 7 set, it is also low whenever enable and master are both set.
- R12: The register offsets are 0 control, 1 status, 2 divider, 3 command and 4 data. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears receive-full on a data read) |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Level interrupt |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 2 | Active-low slave selects |

## Verification
If the edge counter or the length decode is wrong, the frame has the wrong number of SCK edges. The slave model then captures a misaligned word, so the error is visible in the same frame. A wrong sampling phase or bit order corrupts the word read back from the data register right after receive-full sets. Flag faults show in the status byte within one or two clocks of the write, the read or the frame end that should have moved them, and they reach the interrupt pin in the same cycle.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int MAX_W  = 32;
    localparam int DIV_W  = 8;
    localparam int LEN_W  = $clog2(MAX_W + 1);
    localparam int EDGE_W = LEN_W + 1;
    localparam int ADDR_W = 3;
    localparam int NUM_SS = 2;
    localparam int SEL_W  = (NUM_SS > 1) ? $clog2(NUM_SS) : 1;

    localparam logic [ADDR_W-1:0] REG_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] REG_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] REG_DIV  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_CMD  = 3'd3;
    localparam logic [ADDR_W-1:0] REG_DATA = 3'd4;

    localparam int CTRL_RXIE   = 7;
    localparam int CTRL_EN     = 6;
    localparam int CTRL_TXIE   = 5;
    localparam int CTRL_MSTR   = 3;
    localparam int CTRL_TXONLY = 1;

    localparam int CMD_LSB  = 12;
    localparam int CMD_KEEP = 7;
    localparam int CMD_SEL  = 4;
    localparam int CMD_CPOL = 1;
    localparam int CMD_CPHA = 0;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             lsb;
        logic             cpha;
        logic             cpol;
        logic [DIV_W-1:0] div;
    } frame_cfg_t;

    // Length code to bit count; reserved codes fall back to a byte.
    function automatic logic [LEN_W-1:0] code_to_len(input logic [3:0] code);
        logic [LEN_W-1:0] n;
        case (code)
            4'd0:    n = LEN_W'(20);
            4'd1:    n = LEN_W'(24);
            4'd2:    n = LEN_W'(32);
            4'd3, 4'd4, 4'd5, 4'd6: n = LEN_W'(8);
            default: n = LEN_W'(code) + LEN_W'(1);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/spi_cmd_baud.sv
module spi_cmd_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_t;

    baud_t q, d;

    always_comb begin
        d      = q;
        tick_o = run_i && (q.cnt == div_i);
        if (!run_i)      d.cnt = '0;
        else if (tick_o) d.cnt = '0;
        else             d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // R2
    count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_i |-> (q.cnt <= div_i));

endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift
    import spi_cmd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  frame_cfg_t       cfg_i,
    input  logic [MAX_W-1:0] tx_i,
    input  logic             miso_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [MAX_W-1:0] rx_o,
    output logic             sck_o,
    output logic             mosi_o
);

    typedef struct packed {
        logic              busy;
        logic [EDGE_W-1:0] edges;
        logic              tog;
        logic [MAX_W-1:0]  tx;
        logic [MAX_W-1:0]  rx;
        frame_cfg_t        cfg;
    } eng_t;

    eng_t q, d;

    logic              tick;
    logic [EDGE_W-1:0] lenx;
    logic [EDGE_W-1:0] half;
    logic [EDGE_W-1:0] pos;
    logic              mosi_bit;
    logic              done;

    spi_cmd_baud #(.DIV_W(DIV_W)) i_baud (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (q.busy),
        .div_i  (q.cfg.div),
        .tick_o (tick)
    );

    always_comb begin
        d    = q;
        done = 1'b0;
        lenx = {1'b0, q.cfg.len};

        // Index of the bit currently on the wire, derived from edges seen.
        if (q.edges == '0)   half = '0;
        else if (q.cfg.cpha) half = (q.edges - 1'b1) >> 1;
        else                 half = q.edges >> 1;
        if (half >= lenx)    half = lenx - 1'b1;
        pos = q.cfg.lsb ? half : (lenx - 1'b1 - half);

        mosi_bit = 1'b0;
        for (int b = 0; b < MAX_W; b++) begin
            if (pos == EDGE_W'(b)) mosi_bit = q.tx[b];
        end

        if (start_i) begin
            d.busy  = 1'b1;
            d.edges = '0;
            d.tog   = 1'b0;
            d.tx    = tx_i;
            d.rx    = '0;
            d.cfg   = cfg_i;
        end else if (q.busy && tick) begin
            if (q.edges[0] == q.cfg.cpha) begin
                if (q.cfg.lsb) begin
                    for (int b = 0; b < MAX_W; b++) begin
                        if (half == EDGE_W'(b)) d.rx[b] = miso_i;
                    end
                end else begin
                    d.rx = {q.rx[MAX_W-2:0], miso_i};
                end
            end
            d.edges = q.edges + 1'b1;
            d.tog   = ~q.tog;
            if (d.edges == {q.cfg.len, 1'b0}) begin
                d.busy = 1'b0;
                done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign busy_o = q.busy;
    assign done_o = done;
    assign rx_o   = d.rx;
    assign sck_o  = q.busy ? (q.cfg.cpol ^ q.tog) : cfg_i.cpol;
    assign mosi_o = mosi_bit;

    // R3
    edge_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.busy |-> (q.edges < {q.cfg.len, 1'b0}));

    // R2
    idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !q.busy |-> !q.tog);

endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [MAX_W-1:0]  wdata_i,
    output logic [MAX_W-1:0]  rdata_o,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [MAX_W-1:0]  rx_i,
    output frame_cfg_t        cfg_o,
    output logic [MAX_W-1:0]  tx_o,
    output logic              launch_o,
    output logic              hold_ss_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [7:0]       ctrl;
        logic [DIV_W-1:0] div;
        logic [15:0]      cmd;
        logic [MAX_W-1:0] txbuf;
        logic             buf_v;
        logic             txe;
        logic             rxf;
        logic             ovr;
        logic [MAX_W-1:0] rxdat;
    } regs_t;

    regs_t q, d;

    logic wr_ctrl, wr_stat, wr_div, wr_cmd, wr_data, rd_data, launch, run_ok;

    always_comb begin
        d       = q;
        wr_ctrl = wr_en_i && (addr_i == REG_CTRL);
        wr_stat = wr_en_i && (addr_i == REG_STAT);
        wr_div  = wr_en_i && (addr_i == REG_DIV);
        wr_cmd  = wr_en_i && (addr_i == REG_CMD);
        wr_data = wr_en_i && (addr_i == REG_DATA);
        rd_data = rd_en_i && (addr_i == REG_DATA);
        run_ok  = q.ctrl[CTRL_EN] && q.ctrl[CTRL_MSTR];
        launch  = q.buf_v && run_ok && !busy_i;

        if (wr_ctrl) d.ctrl = wdata_i[7:0];
        if (wr_div)  d.div  = wdata_i[DIV_W-1:0];
        if (wr_cmd)  d.cmd  = wdata_i[15:0];

        if (launch) begin
            d.buf_v = 1'b0;
            d.txe   = 1'b1;
        end
        if (wr_data) begin
            d.txbuf = wdata_i;
            d.buf_v = 1'b1;
            d.txe   = 1'b0;
        end

        if (wr_stat) d.ovr = q.ovr & wdata_i[0];
        if (rd_data) d.rxf = 1'b0;

        if (done_i && !q.ctrl[CTRL_TXONLY]) begin
            if (q.rxf && !rd_data) begin
                d.ovr = 1'b1;
            end else begin
                d.rxdat = rx_i;
                d.rxf   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q     <= '0;
            q.txe <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr_i)
            REG_CTRL: rdata_o = {{(MAX_W-8){1'b0}}, q.ctrl};
            REG_STAT: rdata_o = {{(MAX_W-8){1'b0}}, q.rxf, 1'b0, q.txe, 4'b0000, q.ovr};
            REG_DIV:  rdata_o = {{(MAX_W-DIV_W){1'b0}}, q.div};
            REG_CMD:  rdata_o = {{(MAX_W-16){1'b0}}, q.cmd};
            REG_DATA: rdata_o = q.rxdat;
            default:  rdata_o = '0;
        endcase
    end

    assign cfg_o.len  = code_to_len(q.cmd[11:8]);
    assign cfg_o.lsb  = q.cmd[CMD_LSB];
    assign cfg_o.cpha = q.cmd[CMD_CPHA];
    assign cfg_o.cpol = q.cmd[CMD_CPOL];
    assign cfg_o.div  = q.div;
    assign tx_o       = q.txbuf;
    assign launch_o   = launch;
    assign hold_ss_o  = run_ok && q.cmd[CMD_KEEP];
    assign sel_o      = q.cmd[CMD_SEL +: SEL_W];
    assign irq_o      = (q.rxf && q.ctrl[CTRL_RXIE]) || (q.txe && q.ctrl[CTRL_TXIE]);

    // R7
    rxf_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.rxf) |-> $past(done_i));

    // R9
    ovr_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.ovr) |-> $past(done_i && q.rxf));

    // R6
    txe_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.txe) |-> busy_i);

endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
    import spi_cmd_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [MAX_W-1:0]  wdata_i,
    output logic [MAX_W-1:0]  rdata_o,
    output logic              irq_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [NUM_SS-1:0] ss_n_o
);

    frame_cfg_t       cfg;
    logic [MAX_W-1:0] tx_word;
    logic [MAX_W-1:0] rx_word;
    logic             launch, busy, done, hold_ss, ss_on;
    logic [SEL_W-1:0] sel;

    spi_cmd_regs i_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .busy_i    (busy),
        .done_i    (done),
        .rx_i      (rx_word),
        .cfg_o     (cfg),
        .tx_o      (tx_word),
        .launch_o  (launch),
        .hold_ss_o (hold_ss),
        .sel_o     (sel),
        .irq_o     (irq_o)
    );

    spi_cmd_shift i_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (launch),
        .cfg_i   (cfg),
        .tx_i    (tx_word),
        .miso_i  (miso_i),
        .busy_o  (busy),
        .done_o  (done),
        .rx_o    (rx_word),
        .sck_o   (sck_o),
        .mosi_o  (mosi_o)
    );

    assign ss_on = busy || hold_ss;

    for (genvar g = 0; g < NUM_SS; g++) begin : g_ss
        assign ss_n_o[g] = !(ss_on && (sel == SEL_W'(g)));
    end

    // R11
    ss_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~ss_n_o));

    // R11
    ss_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy |-> (ss_n_o != '1));

endmodule

// File: tb/test_spi_cmd_master.sv
module test_spi_cmd_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, sck, mosi, miso;
    logic [1:0]  ss_n;

    int ntests = 0;
    int nfail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    spi_cmd_master i_spi_cmd_master (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
        .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .ss_n_o(ss_n)
    );

    // Behavioural slave
    int          s_cpha = 0, s_lsb = 0, s_len = 8, s_sel = 0;
    logic [31:0] s_word = '0;
    logic [31:0] cap = '0;
    int          seen = 0;
    logic        s_prev = 1'b0;
    bit          s_active = 0;

    function automatic int blen(int code);
        if (code >= 7) return code + 1;
        if (code == 0) return 20;
        if (code == 1) return 24;
        if (code == 2) return 32;
        return 8;
    endfunction

    function automatic int sidx(int sn, int cpha, int len);
        int i;
        if (sn == 0) i = 0;
        else if (cpha != 0) i = (sn - 1) / 2;
        else i = sn / 2;
        if (i > len - 1) i = len - 1;
        return i;
    endfunction

    function automatic int spos(int i, int lsb, int len);
        return (lsb != 0) ? i : (len - 1 - i);
    endfunction

    function automatic logic [31:0] lmask(int len);
        return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
    endfunction

    assign miso = s_word[spos(sidx(seen, s_cpha, s_len), s_lsb, s_len)];

    always @(negedge clk) begin
        if (s_active && (sck != s_prev)) begin
            if ((seen % 2) == s_cpha)
                cap[spos(sidx(seen, s_cpha, s_len), s_lsb, s_len)] = mosi;
            seen = seen + 1;
            if (seen == 2 * s_len) seen = 0;
        end
        s_prev   = sck;
        s_active = !ss_n[s_sel];
        if (!s_active) seen = 0;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        addr = a; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_rxf();
        logic [31:0] st;
        for (int k = 0; k < 3000; k++) begin
            peek(3'd1, st);
            if (st[7]) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] v, tx, exp_rx, cmd, prev_rx;
        int len, idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(3'd1, v);
        check(v == 32'h20, "R1 status", v, 32'h20);
        check(ss_n == 2'b11, "R1 ss_n", {30'd0, ss_n}, 32'd3);
        check(sck == 1'b0 && irq == 1'b0, "R1 sck/irq", {30'd0, sck, irq}, 32'd0);

        // R12 register map readback
        wr(3'd2, 32'h5A);  peek(3'd2, v); check(v == 32'h5A, "R12 div", v, 32'h5A);
        wr(3'd3, 32'h9123); peek(3'd3, v); check(v == 32'h9123, "R12 cmd", v, 32'h9123);
        wr(3'd0, 32'h02);  peek(3'd0, v); check(v == 32'h02, "R12 ctrl", v, 32'h02);

        // Sweep: all length codes, modes and bit orders
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h48);
        idx = 0;
        for (int cpol = 0; cpol < 2; cpol++)
        for (int cpha = 0; cpha < 2; cpha++)
        for (int lsb = 0; lsb < 2; lsb++)
        for (int code = 0; code < 16; code++) begin
            len    = blen(code);
            tx     = 32'hA5C3_1E97 ^ (idx * 32'h9E37_79B9);
            s_word = 32'h6B1D_F04C ^ (idx * 32'h85EB_CA6B);
            s_cpha = cpha; s_lsb = lsb; s_len = len; s_sel = idx % 2;
            cap    = '0;
            cmd = (lsb << 12) | (code << 8) | ((idx % 2) << 4) | (cpol << 1) | cpha;
            wr(3'd3, cmd);
            @(negedge clk);
            peek(3'd0, v);
            check(sck == cpol[0], "R2 idle level", {31'd0, sck}, cpol);
            wr(3'd4, tx);
            if (idx == 0) begin
                peek(3'd1, v);
                check(v[5] == 1'b0, "R6 txe clear after write", v, 32'h0);
                @(negedge clk);
                peek(3'd1, v);
                check(v[5] == 1'b1, "R6 txe set on load", v, 32'h20);
                check(ss_n == 2'b10, "R11 select low in frame", {30'd0, ss_n}, 32'd2);
            end
            wait_rxf();
            @(negedge clk);
            exp_rx = s_word & lmask(len);
            rd(3'd4, v);
            // R3 R4 R5 received word
            check(v == exp_rx, $sformatf("R4/R5 rx code%0d cpol%0d cpha%0d lsb%0d", code, cpol, cpha, lsb), v, exp_rx);
            // R3 R4 R5 transmitted word
            check(cap == (tx & lmask(len)), $sformatf("R3/R5 tx code%0d cpol%0d cpha%0d lsb%0d", code, cpol, cpha, lsb), cap, tx & lmask(len));
            peek(3'd1, v);
            check(v[7] == 1'b0, "R7 rxf cleared by read", v, 32'h20);
            check(sck == cpol[0], "R2 level after frame", {31'd0, sck}, cpol);
            idx++;
        end

        // R2 half-period and edge count for several dividers
        s_sel = 0;
        for (int dv = 0; dv < 6; dv += 2)
        for (int cpol = 0; cpol < 2; cpol++) begin
            int last, edges, bad;
            logic ps;
            wr(3'd2, dv);
            wr(3'd3, 32'h0700 | (cpol << 1));
            s_cpha = 0; s_lsb = 0; s_len = 8;
            wr(3'd4, 32'h55);
            last = -1; edges = 0; bad = 0; ps = sck;
            for (int c = 0; c < 400; c++) begin
                @(negedge clk);
                #1;
                if (sck != ps) begin
                    if (last >= 0 && (c - last) != dv + 1) bad++;
                    last = c; edges++; ps = sck;
                end
            end
            check(bad == 0, $sformatf("R2 half period div%0d", dv), bad, 0);
            check(edges == 16, "R3 edge count", edges, 16);
            rd(3'd4, v);
        end
        wr(3'd2, 32'h0);

        // R8 transmit-only
        wr(3'd3, 32'h0700);
        s_cpha = 0; s_lsb = 0; s_len = 8; s_word = 32'h11;
        wr(3'd4, 32'hAB); wait_rxf(); rd(3'd4, prev_rx);
        wr(3'd0, 32'h4A);
        s_word = 32'hEE;
        wr(3'd4, 32'hCD);
        repeat (40) @(negedge clk);
        peek(3'd1, v);
        check(v == 32'h20, "R8 rxf stays clear", v, 32'h20);
        peek(3'd4, v);
        check(v == prev_rx, "R8 data unchanged", v, prev_rx);
        wr(3'd0, 32'h48);

        // R9 overrun
        s_word = 32'h3C;
        wr(3'd4, 32'h01); wait_rxf();
        s_word = 32'hC5;
        wr(3'd4, 32'h02);
        repeat (40) @(negedge clk);
        peek(3'd1, v);
        check(v == 32'hA1, "R9 overrun set", v, 32'hA1);
        rd(3'd4, v);
        check(v == 32'h3C, "R9 first word kept", v, 32'h3C);
        wr(3'd1, 32'h01); peek(3'd1, v);
        check(v == 32'h21, "R9 write 1 keeps", v, 32'h21);
        wr(3'd1, 32'h00); peek(3'd1, v);
        check(v == 32'h20, "R9 write 0 clears", v, 32'h20);

        // R10 interrupt
        wr(3'd0, 32'h68); #1;
        check(irq == 1'b1, "R10 txe irq", irq, 1);
        wr(3'd0, 32'h48); #1;
        check(irq == 1'b0, "R10 masked", irq, 0);
        wr(3'd4, 32'h77); wait_rxf();
        #1 check(irq == 1'b0, "R10 rxf masked", irq, 0);
        wr(3'd0, 32'hC8); #1;
        check(irq == 1'b1, "R10 rxf irq", irq, 1);
        rd(3'd4, v); #1;
        check(irq == 1'b0, "R10 irq drops on read", irq, 0);

        // R11 start gating and keep-asserted select
        wr(3'd0, 32'h40);
        wr(3'd4, 32'h99);
        repeat (30) @(negedge clk);
        peek(3'd1, v);
        check(v[5] == 1'b0 && ss_n == 2'b11, "R11 no start without master", v, 32'h0);
        wr(3'd0, 32'h48); wait_rxf(); rd(3'd4, v);
        wr(3'd0, 32'h00);
        wr(3'd3, 32'h0790); #1;
        check(ss_n == 2'b11, "R11 keep but disabled", {30'd0, ss_n}, 3);
        wr(3'd0, 32'h48); #1;
        check(ss_n == 2'b01, "R11 keep selects line 1", {30'd0, ss_n}, 1);
        wr(3'd0, 32'h40); #1;
        check(ss_n == 2'b11, "R11 released", {30'd0, ss_n}, 3);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            ntests++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

endmodule